// File: doc/BRIEF.md
# Synchronous character hunt detector

This block is the receive-side framing logic of a character-oriented synchronous serial receiver. Serial bits arrive one per strobe of `bit_en`, which marks a rising edge of the receive clock. After an enter-hunt command, the block looks for a programmed sync pattern at a bit granularity. The pattern is either one sync character or a pair that must follow each other. It can instead lock on a qualified pulse from an external sync input. Once locked, it slices the bit stream into characters of the programmed length and delivers each one with a single-cycle strobe.

The character length runs from 5 to 8 bits and an optional parity bit follows the data. The parity bit is framed and skipped, but never checked, and it never takes part in a pattern compare. After lock, every received character is still compared with the first sync character, and a match raises the sticky sync flag again. A status-read strobe clears that flag. A new enter-hunt command can be issued at any moment to drop lock and resynchronise.

Top module: `sync_hunt`

## Requirements
- R1: After reset the block is idle. `in_hunt`, `locked`, `sync_flag` and `char_vld` are all 0, and bits presented while idle are ignored and cause no lock.
- R2: A `hunt_cmd` pulse loads the shift buffer with all ones, drops lock and enters the hunt state. The next cycle shows `in_hunt`=1 and `locked`=0, whatever the previous state.
- R3: Bits are taken LSB first, one per `bit_en`. `char_len` code 0,1,2,3 selects 5,6,7,8 data bits. During an internal hunt the newest character-length window is compared with `sync_ch1` on every shifted bit, using only the low character-length bits. Because of the all-ones preload, an all-ones sync character matches on the first 1 bit received.
- R4: With `par_en`=1 each frame is data plus one trailing parity bit. The parity bit is excluded from every compare and from `char_data`.
- R5: With `two_sync`=1, a match of `sync_ch1` must be followed by a match of `sync_ch2` on exactly the next character before lock. If that second compare fails, bit-by-bit hunting for `sync_ch1` resumes with the following bit.
- R6: `locked` and `sync_flag` become 1 in the cycle after the `bit_en` carrying the final bit of the sync pattern (the parity bit when enabled). The next received bit is bit 0 of the first data character.
- R7: With `ext_mode`=1 no pattern compare takes part in the hunt. Lock happens on the `bit_en` at which `ext_sync_in` is sampled high for the second consecutive time after a low sample.
- R8: While locked, `char_vld` pulses for one cycle, the cycle after the `bit_en` carrying the last bit of each frame. `char_data` then holds the data bits right-justified with the unused upper bits 0. `char_vld` is never raised unless locked.
- R9: `sync_flag` is sticky. It is set on lock, on a locked character equal to `sync_ch1` in its low bits, and in external mode on a further qualified `ext_sync_in` pulse while locked. A `stat_rd` pulse clears it, but a set in the same cycle wins.
- R10: Without `bit_en` or `hunt_cmd` the lock state does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_en | input | 1 | One-cycle strobe: sample `rx_bit` (receive clock rising edge) |
| rx_bit | input | 1 | Serial receive data |
| char_len | input | 2 | Data bits per character minus 5 |
| par_en | input | 1 | Frame carries a trailing parity bit |
| two_sync | input | 1 | Pattern is two sync characters |
| sync_ch1 | input | 8 | First sync character |
| sync_ch2 | input | 8 | Second sync character |
| ext_mode | input | 1 | Lock on external sync input instead of pattern |
| ext_sync_in | input | 1 | External sync input |
| hunt_cmd | input | 1 | Enter-hunt command pulse |
| stat_rd | input | 1 | Status read strobe; clears `sync_flag` |
| char_vld | output | 1 | Received character strobe |
| char_data | output | 8 | Received character, right-justified |
| in_hunt | output | 1 | Hunt phase active |
| locked | output | 1 | Character synchronisation achieved |
| sync_flag | output | 1 | Sticky sync-detected flag |

## Verification
The bound checker watches, on every cycle, the rules that need no knowledge of the bit stream. A hunt command always leaves the block hunting and unlocked. Lock never rises without the flag. Characters appear only while locked and only right after a bit strobe. A status read with no bit strobe clears the flag. The lock state holds still between strobes. Whether the pattern is found at the right bit, including the parity skip, the all-ones preload, the two-character sequence with its restart, and the external two-sample qualification, can only be shown by the bench's scenarios. The same applies to the contents of each delivered character, which the bench compares against expected bit indices and values.

// File: rtl/sync_hunt.sv
module sync_hunt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bit_en,
  input  logic         rx_bit,
  input  logic [1:0]   char_len,
  input  logic         par_en,
  input  logic         two_sync,
  input  logic [W-1:0] sync_ch1,
  input  logic [W-1:0] sync_ch2,
  input  logic         ext_mode,
  input  logic         ext_sync_in,
  input  logic         hunt_cmd,
  input  logic         stat_rd,
  output logic         char_vld,
  output logic [W-1:0] char_data,
  output logic         in_hunt,
  output logic         locked,
  output logic         sync_flag
);
  localparam int FW   = W + 1;
  localparam int MINL = W - 3;
  localparam int CW   = $clog2(FW + 1);

  typedef enum logic [1:0] {IDLE, HUNT1, HUNT2, LOCK} st_t;

  st_t           st;
  logic [FW-1:0] sr;
  logic [CW-1:0] cnt;
  logic [1:0]    ext_h;

  logic [FW-1:0] sr_n, win;
  logic [CW-1:0] len, flen;
  logic [W-1:0]  mask, data_n;
  logic          m1, m2, ext_ok, last, set_flag;

  assign sr_n   = {rx_bit, sr[FW-1:1]};
  assign len    = CW'(MINL) + CW'(char_len);
  assign flen   = len + CW'(par_en);
  assign win    = sr_n >> (CW'(FW) - flen);
  assign mask   = W'((FW'(1) << len) - FW'(1));
  assign data_n = W'(win) & mask;
  assign m1     = data_n == (sync_ch1 & mask);
  assign m2     = data_n == (sync_ch2 & mask);
  assign ext_ok = ext_sync_in && ext_h[0] && !ext_h[1];
  assign last   = cnt == flen - CW'(1);

  assign in_hunt = (st == HUNT1) || (st == HUNT2);
  assign locked  = st == LOCK;

  always_comb begin
    set_flag = 1'b0;
    if (bit_en && !hunt_cmd) begin
      case (st)
        HUNT1:   set_flag = ext_mode ? ext_ok : (m1 && !two_sync);
        HUNT2:   set_flag = last && m2;
        LOCK:    set_flag = (last && m1) || (ext_mode && ext_ok);
        default: set_flag = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= IDLE;
      sr        <= '1;
      cnt       <= '0;
      ext_h     <= '0;
      char_vld  <= 1'b0;
      char_data <= '0;
    end else begin
      char_vld <= 1'b0;
      if (bit_en) ext_h <= {ext_h[0], ext_sync_in};
      if (hunt_cmd) begin
        st  <= HUNT1;
        sr  <= '1;
        cnt <= '0;
      end else if (bit_en && st != IDLE) begin
        sr <= sr_n;
        case (st)
          HUNT1: begin
            cnt <= '0;
            if (ext_mode) begin
              if (ext_ok) st <= LOCK;
            end else if (m1) begin
              st <= two_sync ? HUNT2 : LOCK;
            end
          end
          HUNT2: begin
            if (last) begin
              cnt <= '0;
              st  <= m2 ? LOCK : HUNT1;
            end else begin
              cnt <= cnt + CW'(1);
            end
          end
          LOCK: begin
            if (last) begin
              cnt       <= '0;
              char_vld  <= 1'b1;
              char_data <= data_n;
            end else begin
              cnt <= cnt + CW'(1);
            end
          end
          default: st <= IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sync_flag <= 1'b0;
    else if (set_flag) sync_flag <= 1'b1;
    else if (stat_rd)  sync_flag <= 1'b0;
  end
endmodule

module sync_hunt_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_en,
  input logic hunt_cmd,
  input logic stat_rd,
  input logic char_vld,
  input logic in_hunt,
  input logic locked,
  input logic sync_flag
);
  // R2
  hunt_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hunt_cmd |=> in_hunt && !locked);
  // R6
  lock_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> sync_flag);
  // R8
  vld_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    char_vld |-> locked);
  // R8
  vld_after_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    char_vld |-> $past(bit_en));
  // R9
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !bit_en) |=> !sync_flag);
  // R10
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_en && !hunt_cmd) |=> locked == $past(locked));
  // R1
  phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_hunt && locked));
endmodule

bind sync_hunt sync_hunt_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .hunt_cmd(hunt_cmd),
  .stat_rd(stat_rd), .char_vld(char_vld), .in_hunt(in_hunt),
  .locked(locked), .sync_flag(sync_flag)
);

// File: tb/sync_hunt_tb.sv
module sync_hunt_tb;
  logic clk = 0, rst_n = 0, bit_en = 0, rx_bit = 1;
  logic [1:0] char_len = 0;
  logic par_en = 0, two_sync = 0, ext_mode = 0, ext_sync_in = 0;
  logic hunt_cmd = 0, stat_rd = 0;
  logic [7:0] sync_ch1 = 0, sync_ch2 = 0;
  logic char_vld, in_hunt, locked, sync_flag;
  logic [7:0] char_data;

  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  sync_hunt u_dut (.*);

  typedef struct packed {
    logic [1:0]  len;
    logic        par;
    logic        two;
    logic [7:0]  c1;
    logic [7:0]  c2;
    logic [31:0] bits;
    logic [5:0]  nb;
    logic [5:0]  lock_at;
    logic [5:0]  chr_at;
    logic [7:0]  chr;
  } vec_t;

  // R3 5-bit; R4 8-bit+parity; R5 pair; R5 pair with failed second; R3 all-ones preload
  localparam vec_t VEC [5] = '{
    '{2'd0, 1'b0, 1'b0, 8'h0C, 8'h00, 32'h00000AB3, 6'd12, 6'd6,  6'd11, 8'h15},
    '{2'd3, 1'b1, 1'b0, 8'h16, 8'h00, 32'h00014B16, 6'd18, 6'd8,  6'd17, 8'hA5},
    '{2'd1, 1'b0, 1'b1, 8'h2D, 8'h12, 32'h0003A4AD, 6'd18, 6'd11, 6'd17, 8'h3A},
    '{2'd0, 1'b0, 1'b1, 8'h0C, 8'h13, 32'h00A9B3EC, 6'd25, 6'd19, 6'd24, 8'h0A},
    '{2'd2, 1'b0, 1'b0, 8'h7F, 8'h00, 32'h00000001, 6'd8,  6'd0,  6'd7,  8'h00}
  };

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic b);
    @(negedge clk); rx_bit = b; bit_en = 1;
    @(negedge clk); bit_en = 0;
  endtask

  task automatic pulse_hunt;
    @(negedge clk); hunt_cmd = 1;
    @(negedge clk); hunt_cmd = 0;
  endtask

  task automatic pulse_rd;
    @(negedge clk); stat_rd = 1;
    @(negedge clk); stat_rd = 0;
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog act=0 exp=1");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    int lock_at, chr_at, flg;
    logic [7:0] chr;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!locked && !in_hunt && !sync_flag && !char_vld, "R1 reset state",
        {locked, in_hunt, sync_flag, char_vld}, 0);
    sync_ch1 = 8'h1F;
    for (int i = 0; i < 6; i++) send(1'b1);
    chk(!locked && !sync_flag, "R1 idle bits ignored", {locked, sync_flag}, 0);

    for (int v = 0; v < 5; v++) begin
      char_len = VEC[v].len; par_en = VEC[v].par; two_sync = VEC[v].two;
      sync_ch1 = VEC[v].c1; sync_ch2 = VEC[v].c2; ext_mode = 0;
      pulse_rd();
      pulse_hunt();
      chk(in_hunt && !locked, "R2 hunt entry", {in_hunt, locked}, 2);
      lock_at = -1; chr_at = -1; chr = 0; flg = 0;
      for (int i = 0; i < int'(VEC[v].nb); i++) begin
        send(VEC[v].bits[i]);
        if (locked && lock_at < 0) begin lock_at = i; flg = sync_flag; end
        if (char_vld && chr_at < 0) begin chr_at = i; chr = char_data; end
      end
      chk(lock_at == int'(VEC[v].lock_at), "R3 R5 R6 lock bit", lock_at, VEC[v].lock_at);
      chk(flg == 1, "R6 flag at lock", flg, 1);
      chk(chr_at == int'(VEC[v].chr_at), "R8 char strobe bit", chr_at, VEC[v].chr_at);
      chk(chr == VEC[v].chr, "R4 R8 char data", chr, VEC[v].chr);
    end

    pulse_rd();
    chk(!sync_flag, "R9 cleared by status read", sync_flag, 0);
    for (int i = 0; i < 7; i++) send(1'b1);
    chk(char_vld && char_data == 8'h7F, "R8 sync char delivered", char_data, 8'h7F);
    chk(sync_flag, "R9 flag reset by locked sync char", sync_flag, 1);

    pulse_hunt();
    chk(in_hunt && !locked, "R2 rehunt while locked", {in_hunt, locked}, 2);

    char_len = 0; par_en = 0; two_sync = 0; sync_ch1 = 8'h00; ext_mode = 1;
    ext_sync_in = 0;
    pulse_rd();
    pulse_hunt();
    for (int i = 0; i < 6; i++) send(1'b0);
    chk(!locked, "R7 no pattern lock in external mode", locked, 0);
    ext_sync_in = 1;
    send(1'b0);
    chk(!locked, "R7 single high sample not enough", locked, 0);
    send(1'b0);
    chk(locked && sync_flag, "R7 lock on second high sample", {locked, sync_flag}, 3);
    chk_ext_char: begin
      logic [4:0] pat = 5'b11001;
      for (int i = 0; i < 5; i++) send(pat[i]);
      chk(char_vld && char_data == 8'h19, "R7 R8 first char after external lock",
          char_data, 8'h19);
    end
    repeat (4) @(negedge clk);
    chk(locked, "R10 lock held without strobes", locked, 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule